// File: doc/BRIEF.md
# PHY clock handshake sequencer

This block takes a serial-link PHY out of reset by driving a small register master port. After a start pulse it sets the first clock-request bit in the PHY control register and polls that register until the matching acknowledge bit appears. It then does the same for the second clock. Only after both acknowledges have been seen does it clear the PHY reset bit. A settle delay follows, then it sets an enable bit in the root-complex region, and a second settle delay follows that. At the end it raises a done flag.

Every bit change is a read followed by a write of the value read with one bit changed, so the other control bits keep their values. If an acknowledge poll runs past its cycle budget, the sequence stops and reports which of the two clocks failed. The settle delay is a cycle count derived from a clock-frequency parameter. The start input is taken only when the sequencer is idle, finished or in error.

Top module: `phy_clk_seq`

## Requirements
- R1: While reset is held and after its release, done_o, err_o and bus_req_o are low and err_stage_o is 0, until start_i is seen.
- R2: Start reads the control register at PHY_BASE+0x000 and writes the value read back with bit 0 (clock 0 request) set. All other bits keep the value that was read.
- R3: After the bit-0 request, the block polls the control register with reads until one returns bit 2 (clock 0 acknowledge) set. Bit 1 is not written before that read.
- R4: After the clock 0 acknowledge, the block sets bit 1 (clock 1 request) by read-modify-write and polls until a read returns bit 3 (clock 1 acknowledge) set.
- R5: A poll read that completes with the acknowledge bit clear, TIMEOUT_CYC or more cycles after the poll began, ends the sequence. err_o rises, err_stage_o reads 1 for clock 0 or 2 for clock 1, and no further bus access is made.
- R6: Only after both acknowledges, the block clears bit 7 (PHY reset) of the control register by read-modify-write and keeps the other bits.
- R7: At least CLK_MHZ*SETTLE_US cycles after the reset-release write, the block sets bit 0 of the register at RC_BASE+0x24 by read-modify-write.
- R8: done_o rises at least CLK_MHZ*SETTLE_US cycles after the root-complex write and stays high until the next start.
- R9: err_o and err_stage_o hold their values until the next start. A start taken in the finished or error state drops done_o and err_o on the next cycle.
- R10: A start pulse that arrives while a sequence is running has no effect on that sequence.
- R11: A bus request keeps its address, direction and write data unchanged until bus_ack_i completes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a bring-up sequence |
| done_o | output | 1 | Sequence finished without error |
| err_o | output | 1 | Sequence aborted on a timeout |
| err_stage_o | output | 2 | Stage that timed out: 0 none, 1 clock 0, 2 clock 1 |
| bus_req_o | output | 1 | Register access request, held until ack |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ack_i |
| bus_ack_i | input | 1 | Completes the pending access |

## Verification
The bench pre-loads unrelated control bits and a root-complex register value so it can show that each read-modify-write preserves them. A design that wrote constants would change those bits. Acknowledges arrive immediately, late, or never at each of the two stages. This catches a sequencer that requests clock 1 early, releases reset before the second acknowledge, reports the wrong stage, or times out too soon or too late. The bench times the gaps between the reset-release write, the root-complex write and done, so a shortened settle delay shows up. It also sends an extra start during a poll and checks that no extra writes appear, which catches a design that restarts or duplicates its accesses.

// File: rtl/phy_seq_pkg.sv
`timescale 1ns/1ps
package phy_seq_pkg;
  localparam int CTRL_OFS  = 'h000;
  localparam int RC_EN_OFS = 'h024;
  localparam int B_REQ0    = 0;
  localparam int B_REQ1    = 1;
  localparam int B_ACK0    = 2;
  localparam int B_ACK1    = 3;
  localparam int B_RST     = 7;
  localparam int B_RC_EN   = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_WR0, S_PL0, S_RD1, S_WR1, S_PL1,
    S_RDR, S_WRR, S_SET1, S_RDC, S_WRC, S_SET2, S_DONE, S_ERR
  } seq_st_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CLK0 = 2'd1,
    ERR_CLK1 = 2'd2
  } err_e;
endpackage

// File: rtl/phy_seq_cnt.sv
`timescale 1ns/1ps
module phy_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (cnt_o != {W{1'b1}}) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/phy_seq_bus.sv
`timescale 1ns/1ps
module phy_seq_bus #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_we_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              cmd_done_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i
);
  assign cmd_done_o = bus_req_o & bus_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else if (bus_req_o) begin
      if (bus_ack_i) bus_req_o <= 1'b0;
    end else if (cmd_valid_i) begin
      bus_req_o   <= 1'b1;
      bus_we_o    <= cmd_we_i;
      bus_addr_o  <= cmd_addr_i;
      bus_wdata_o <= cmd_wdata_i;
    end
  end
endmodule

// File: rtl/phy_clk_seq.sv
`timescale 1ns/1ps
module phy_clk_seq
  import phy_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int CLK_MHZ     = 125,
  parameter int SETTLE_US   = 1,
  parameter int TIMEOUT_CYC = 50000,
  parameter logic [ADDR_W-1:0] PHY_BASE = 'h0000,
  parameter logic [ADDR_W-1:0] RC_BASE  = 'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_stage_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i
);
  localparam int SETTLE_CYC = (CLK_MHZ * SETTLE_US < 1) ? 1 : CLK_MHZ * SETTLE_US;
  localparam int LIM_MAX    = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
  localparam int CNT_W      = $clog2(LIM_MAX + 2);
  localparam logic [CNT_W-1:0] TMO_LIM = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SETTLE_CYC - 1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = PHY_BASE + ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] RC_ADDR   = RC_BASE + ADDR_W'(RC_EN_OFS);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  seq_st_e            st_q, st_d;
  err_e               err_q, err_d;
  logic [DATA_W-1:0]  shadow_q;
  logic [CNT_W-1:0]   cnt;
  logic               cnt_clr;
  logic               cmd_valid, cmd_we, cmd_done, need_bus;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [DATA_W-1:0]  cmd_wdata;

  phy_seq_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  phy_seq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_we_i    (cmd_we),
    .cmd_addr_i  (cmd_addr),
    .cmd_wdata_i (cmd_wdata),
    .cmd_done_o  (cmd_done),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i)
  );

  // Bus command decode per state
  always_comb begin
    need_bus  = 1'b1;
    cmd_we    = 1'b0;
    cmd_addr  = CTRL_ADDR;
    cmd_wdata = shadow_q;
    unique case (st_q)
      S_RD0, S_PL0, S_RD1, S_PL1, S_RDR: ;
      S_WR0: begin cmd_we = 1'b1; cmd_wdata = shadow_q | (ONE << B_REQ0); end
      S_WR1: begin cmd_we = 1'b1; cmd_wdata = shadow_q | (ONE << B_REQ1); end
      S_WRR: begin cmd_we = 1'b1; cmd_wdata = shadow_q & ~(ONE << B_RST); end
      S_RDC: cmd_addr = RC_ADDR;
      S_WRC: begin cmd_we = 1'b1; cmd_addr = RC_ADDR; cmd_wdata = shadow_q | (ONE << B_RC_EN); end
      default: need_bus = 1'b0;
    endcase
    cmd_valid = need_bus & ~bus_req_o;
  end

  // Sequence control
  always_comb begin
    st_d    = st_q;
    err_d   = err_q;
    cnt_clr = 1'b0;
    unique case (st_q)
      S_IDLE, S_DONE, S_ERR:
        if (start_i) begin
          st_d  = S_RD0;
          err_d = ERR_NONE;
        end
      S_RD0: if (cmd_done) st_d = S_WR0;
      S_WR0: if (cmd_done) begin st_d = S_PL0; cnt_clr = 1'b1; end
      S_PL0:
        if (cmd_done) begin
          if (bus_rdata_i[B_ACK0])  st_d = S_RD1;
          else if (cnt >= TMO_LIM) begin st_d = S_ERR; err_d = ERR_CLK0; end
        end
      S_RD1: if (cmd_done) st_d = S_WR1;
      S_WR1: if (cmd_done) begin st_d = S_PL1; cnt_clr = 1'b1; end
      S_PL1:
        if (cmd_done) begin
          if (bus_rdata_i[B_ACK1])  st_d = S_RDR;
          else if (cnt >= TMO_LIM) begin st_d = S_ERR; err_d = ERR_CLK1; end
        end
      S_RDR: if (cmd_done) st_d = S_WRR;
      S_WRR: if (cmd_done) begin st_d = S_SET1; cnt_clr = 1'b1; end
      S_SET1: if (cnt >= SET_LIM) st_d = S_RDC;
      S_RDC: if (cmd_done) st_d = S_WRC;
      S_WRC: if (cmd_done) begin st_d = S_SET2; cnt_clr = 1'b1; end
      S_SET2: if (cnt >= SET_LIM) st_d = S_DONE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      err_q    <= ERR_NONE;
      shadow_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (cmd_done && !bus_we_o) shadow_q <= bus_rdata_i;
    end
  end

  assign done_o      = (st_q == S_DONE);
  assign err_o       = (st_q == S_ERR);
  assign err_stage_o = err_q;
endmodule

// File: rtl/phy_clk_seq_chk.sv
`timescale 1ns/1ps
module phy_clk_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic              err_o,
  input logic [1:0]        err_stage_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i
);
  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
                                && $stable(bus_wdata_o));

  a_r5_err_has_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_stage_o != 2'd0);

  a_r5_err_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && $past(err_o) |-> !bus_req_o);

  a_r8_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  a_r9_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o && $stable(err_stage_o));

  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (done_o || err_o) |=> !done_o && !err_o);

  a_r8_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
endmodule

bind phy_clk_seq phy_clk_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/phy_clk_seq_tb.sv
`timescale 1ns/1ps
module phy_clk_seq_tb;
  localparam int TMO      = 200;
  localparam int SETTLE   = 125;
  localparam int NEVER    = 32'h7FFF_FFFF;
  localparam logic [15:0] CTRL_A = 16'h0000;
  localparam logic [15:0] RC_A   = 16'h1024;

  typedef struct packed {
    int          d0;
    int          d1;
    logic [7:0]  pre;
    logic [1:0]  stage;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{d0: 3,     d1: 5,     pre: 8'h80, stage: 2'd0},
    '{d0: 0,     d1: 0,     pre: 8'hF0, stage: 2'd0},
    '{d0: 40,    d1: 1,     pre: 8'hA0, stage: 2'd0},
    '{d0: NEVER, d1: 2,     pre: 8'h80, stage: 2'd1},
    '{d0: 2,     d1: NEVER, pre: 8'hC0, stage: 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        done, err;
  logic [1:0]  err_stage;
  logic        req, we;
  logic [15:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata = '0;
  logic        ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // model state
  logic [31:0] ctrl_q, rc_q;
  int d0, d1, c0, c1, wr_cnt, t_w0, t_w1, t_wr, t_wc;
  bit req0_seen, req1_seen, ack0_dut, ack1_dut;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_clk_seq #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .done_o(done), .err_o(err), .err_stage_o(err_stage),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr),
    .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_ack_i(ack)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic bit ack0_on();
    return req0_seen && d0 != NEVER && (cyc - c0) >= d0;
  endfunction
  function automatic bit ack1_on();
    return req1_seen && d1 != NEVER && (cyc - c1) >= d1;
  endfunction

  task automatic model_reset(input logic [7:0] pre, input int a0, input int a1);
    ctrl_q = {24'h0, pre}; rc_q = 32'h10;
    d0 = a0; d1 = a1; c0 = 0; c1 = 0; wr_cnt = 0;
    t_w0 = 0; t_w1 = 0; t_wr = 0; t_wc = 0;
    req0_seen = 0; req1_seen = 0; ack0_dut = 0; ack1_dut = 0;
  endtask

  // behavioural PHY / root-complex register model, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else if (ack) ack <= 1'b0;
    else if (req) begin
      ack <= 1'b1;
      if (addr == CTRL_A) begin
        if (we) begin
          logic [31:0] nv;
          nv = wdata & ~32'hC;
          if (nv[0] && !ctrl_q[0]) begin req0_seen = 1; c0 = cyc; t_w0 = cyc; end
          if (nv[1] && !ctrl_q[1]) begin
            chk(ack0_dut, "R3 clk1 request before clk0 ack", 32'(ack0_dut), 1);
            req1_seen = 1; c1 = cyc; t_w1 = cyc;
          end
          if (!nv[7] && ctrl_q[7]) begin
            chk(ack1_dut, "R6 reset released before clk1 ack", 32'(ack1_dut), 1);
            t_wr = cyc;
          end
          ctrl_q = nv; wr_cnt++;
        end else begin
          if (ack0_on()) ack0_dut = 1;
          if (ack1_on()) ack1_dut = 1;
          rdata <= ctrl_q | {28'h0, ack1_on(), ack0_on(), 2'b00};
        end
      end else if (addr == RC_A) begin
        if (we) begin
          chk(!ctrl_q[7], "R7 rc enable before reset release", ctrl_q, 0);
          rc_q = wdata; t_wc = cyc; wr_cnt++;
        end else rdata <= rc_q;
      end else begin
        chk(1'b0, "R2 unexpected address", 32'(addr), 32'(CTRL_A));
        rdata <= '0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    finish_run();
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(output int t_end);
    for (int n = 0; n < 5000 && !(done || err); n++) @(negedge clk);
    t_end = cyc;
  endtask

  initial begin
    int t_end;
    model_reset(8'h80, 1, 1);
    repeat (3) @(negedge clk);
    chk(!done && !err && !req, "R1 outputs during reset", {done, err, req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done && !err && !req && err_stage == 0, "R1 idle after reset",
        {err_stage, done, err, req}, 0);

    // vector table
    for (int i = 0; i < 5; i++) begin
      vec_t v;
      v = VECS[i];
      model_reset(v.pre, v.d0, v.d1);
      pulse_start();
      chk(!done && !err, "R9 start clears flags", {done, err}, 0);
      wait_end(t_end);
      if (v.stage == 2'd0) begin
        chk(done && !err, "R8 done raised", {done, err}, 2'b10);
        chk(ctrl_q == ((32'(v.pre) | 32'h3) & ~32'h80), "R6 final ctrl (R2 R4 RMW)",
            ctrl_q, (32'(v.pre) | 32'h3) & ~32'h80);
        chk(rc_q == 32'h11, "R7 rc enable RMW", rc_q, 32'h11);
        chk(wr_cnt == 4, "R3 write count", wr_cnt, 4);
        chk(t_wc - t_wr >= SETTLE, "R7 first settle", t_wc - t_wr, SETTLE);
        chk(t_end - t_wc >= SETTLE, "R8 second settle", t_end - t_wc, SETTLE);
        repeat (20) @(negedge clk);
        chk(done && !req, "R8 done held", {done, req}, 2'b10);
      end else begin
        int t_ref;
        t_ref = (v.stage == 2'd1) ? t_w0 : t_w1;
        chk(err && !done, "R5 error raised", {done, err}, 2'b01);
        chk(err_stage == v.stage, "R5 stage code", err_stage, v.stage);
        chk(t_end - t_ref >= TMO && t_end - t_ref <= TMO + 12, "R5 timeout window",
            t_end - t_ref, TMO);
        chk(ctrl_q == (32'(v.pre) | ((v.stage == 2'd1) ? 32'h1 : 32'h3)),
            "R5 ctrl at abort, reset kept", ctrl_q,
            32'(v.pre) | ((v.stage == 2'd1) ? 32'h1 : 32'h3));
        chk(rc_q == 32'h10, "R5 rc untouched", rc_q, 32'h10);
        repeat (20) @(negedge clk);
        chk(err && err_stage == v.stage, "R9 error held", {err_stage, err}, {v.stage, 1'b1});
        chk(wr_cnt == ((v.stage == 2'd1) ? 1 : 2), "R5 no writes after abort", wr_cnt,
            (v.stage == 2'd1) ? 1 : 2);
      end
    end

    // start while running
    model_reset(8'h90, 30, 4);
    pulse_start();
    repeat (12) @(negedge clk);
    pulse_start();
    wait_end(t_end);
    chk(done && !err, "R10 done despite extra start", {done, err}, 2'b10);
    chk(wr_cnt == 4, "R10 no extra writes", wr_cnt, 4);
    chk(ctrl_q == 32'h13, "R10 final ctrl", ctrl_q, 32'h13);

    // error to success through a new start
    model_reset(8'h80, NEVER, 0);
    pulse_start();
    wait_end(t_end);
    chk(err && err_stage == 2'd1, "R5 clk0 abort", {err_stage, err}, 3'b011);
    model_reset(8'h80, 1, 1);
    pulse_start();
    chk(!err && err_stage == 0, "R9 start clears error stage", {err_stage, err}, 0);
    wait_end(t_end);
    chk(done, "R8 recovery run done", done, 1);

    finish_run();
  end
endmodule